// File: doc/BRIEF.md
# PCI Interrupt Level Tracker and PIRQ Router

This block turns event-style interrupt messages from on-chip devices into steady interrupt levels. For each of up to 32 PCI-style devices it keeps one level bit per pin (INTA, INTB, INTC, INTD). An assert message sets the bit and a deassert message clears it. A programmable route word per device maps each pin onto one of eight shared lines, PIRQA to PIRQH. Four directly wired serial-IRQ lines are ORed onto PIRQA to PIRQD as well. A shared line stays high while any source mapped to it is high.

A second message kind carries legacy interrupt levels for IRQ3, IRQ4, IRQ14 and IRQ15 toward an 8259-style controller. A steering byte for each shared line sends that line either to a chosen controller IRQ input or to an IO-APIC input. A plain write port loads the route words and the steering bytes. Malformed messages change no state. Instead they raise a one-cycle error pulse.

Top module: `pirq_router`

## Requirements
- R1: A valid PCI message (`msg_legacy`=0) with `msg_dev` below 32 loads the level bit of pin `msg_pin` (0=INTA to 3=INTD) of that device with `msg_assert` at the next clock edge. A deassert clears only that one bit, so a PIRQ stays high while any other source mapped to it is still high.
- R2: Each device route word is 12 bits wide. Bits 3k+2:3k hold the PIRQ index (0=PIRQA to 7=PIRQH) for pin k. The reset value is 0x688, which maps INTA to A, INTB to B, INTC to C and INTD to D.
- R3: `serirq_int[k]` drives `pirq[k]` for k=0 to 3 combinationally, ORed with the device sources.
- R4: A valid legacy message (`msg_legacy`=1) with `msg_irq` of 3, 4, 14 or 15 loads `pic_irq[msg_irq]` with `msg_assert` at the next edge. The level is held until changed by a later message.
- R5: Each steering byte controls its line as follows. Bit 7 set sends `pirq[p]` to `apic_irq[p]`, which stands for IO-APIC input 16+p. Bit 7 clear ORs `pirq[p]` into `pic_irq[bits 3:0]`. The reset value is 0x80.
- R6: A legacy message with any other IRQ number, or a PCI message with `msg_dev` of 32 or more, changes no state. It raises `msg_err` for exactly the following cycle.
- R7: A write with `cfg_we` goes to one of three places. Addresses 0 to 31 load a device route word from `cfg_wdata[11:0]`. Addresses 32 to 39 load the steering byte of PIRQ (address−32) from `cfg_wdata[7:0]`. Any other address is ignored. A write takes effect at the next edge.
- R8: After reset all levels are clear. With the serial lines low, `pirq`, `pic_irq`, `apic_irq` and `msg_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_legacy | input | 1 | 1 = legacy IRQ message, 0 = PCI pin message |
| msg_assert | input | 1 | 1 = assert, 0 = deassert |
| msg_dev | input | 6 | Source device index |
| msg_pin | input | 2 | Pin 0..3 = INTA..INTD |
| msg_irq | input | 4 | Legacy IRQ number |
| serirq_int | input | 4 | Serial-IRQ INTA..INTD levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 12 | Configuration write data |
| pirq | output | 8 | PIRQA..PIRQH levels |
| pic_irq | output | 16 | Level per 8259 IRQ input |
| apic_irq | output | 8 | Levels for IO-APIC inputs 16..23 |
| msg_err | output | 1 | One-cycle pulse for a rejected message |

## Verification
The hardest case to reach is a shared line held by two sources while one of them withdraws. The line must stay high until the last source drops, and the deassert must not disturb the other device's bit. The stimulus table asserts the same pin on two devices and then deasserts them one at a time, checking PIRQA after each step. Directed tests then reprogram a route word and a steering byte so that a pin lands on PIRQH and then on a controller IRQ. They also confirm that a write to an unused address leaves that path untouched.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NDEV = 32,
  parameter int DEVW = 6,
  parameter int ADRW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_valid,
  input  logic            msg_legacy,
  input  logic            msg_assert,
  input  logic [DEVW-1:0] msg_dev,
  input  logic [1:0]      msg_pin,
  input  logic [3:0]      msg_irq,
  input  logic [3:0]      serirq_int,
  input  logic            cfg_we,
  input  logic [ADRW-1:0] cfg_addr,
  input  logic [11:0]     cfg_wdata,
  output logic [7:0]      pirq,
  output logic [15:0]     pic_irq,
  output logic [7:0]      apic_irq,
  output logic            msg_err
);
  localparam int DI = $clog2(NDEV);
  localparam logic [11:0] ROUTE_RST = 12'h688;
  localparam logic [7:0]  STEER_RST = 8'h80;

  logic [NDEV-1:0][3:0]  lvl;
  logic [NDEV-1:0][11:0] route;
  logic [7:0][7:0]       steer;
  logic [3:0]            leg;
  logic                  err_q;

  logic       leg_ok;
  logic [1:0] leg_slot;
  always_comb begin
    leg_ok = 1'b1;
    case (msg_irq)
      4'd3:    leg_slot = 2'd0;
      4'd4:    leg_slot = 2'd1;
      4'd14:   leg_slot = 2'd2;
      4'd15:   leg_slot = 2'd3;
      default: begin leg_slot = 2'd0; leg_ok = 1'b0; end
    endcase
  end

  wire dev_ok  = msg_dev < DEVW'(NDEV);
  wire pci_hit = msg_valid & ~msg_legacy & dev_ok;
  wire leg_hit = msg_valid & msg_legacy & leg_ok;
  wire bad_msg = msg_valid & (msg_legacy ? ~leg_ok : ~dev_ok);
  wire rte_wr  = cfg_we & (cfg_addr < ADRW'(NDEV));
  wire str_wr  = cfg_we & ~rte_wr & (cfg_addr < ADRW'(NDEV + 8));
  wire [ADRW-1:0] str_off = cfg_addr - ADRW'(NDEV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= '0;
      route <= {NDEV{ROUTE_RST}};
      steer <= {8{STEER_RST}};
      leg   <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= bad_msg;
      if (pci_hit) lvl[msg_dev[DI-1:0]][msg_pin] <= msg_assert;
      if (leg_hit) leg[leg_slot] <= msg_assert;
      if (rte_wr) route[cfg_addr[DI-1:0]] <= cfg_wdata;
      if (str_wr) steer[str_off[2:0]] <= cfg_wdata[7:0];
    end
  end

  logic [7:0]  pirq_c;
  logic [15:0] pic_c;
  logic [7:0]  apic_c;
  always_comb begin
    pirq_c = {4'b0, serirq_int};
    for (int d = 0; d < NDEV; d++)
      for (int k = 0; k < 4; k++)
        if (lvl[d][k]) pirq_c[route[d][3*k +: 3]] = 1'b1;
  end

  always_comb begin
    pic_c = '0;
    pic_c[3]  = leg[0];
    pic_c[4]  = leg[1];
    pic_c[14] = leg[2];
    pic_c[15] = leg[3];
    for (int p = 0; p < 8; p++) begin
      apic_c[p] = pirq_c[p] & steer[p][7];
      if (pirq_c[p] && !steer[p][7]) pic_c[steer[p][3:0]] = 1'b1;
    end
  end

  assign pirq     = pirq_c;
  assign pic_irq  = pic_c;
  assign apic_irq = apic_c;
  assign msg_err  = err_q;

  assert_err_needs_msg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_err |-> $past(msg_valid));
  assert_err_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !msg_err);
  assert_legacy_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_legacy && msg_assert && msg_irq == 4'd3) |=> pic_irq[3]);
  assert_apic_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apic_irq & ~pirq) == 8'h00);
  assert_serial_reaches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (serirq_int & ~pirq[3:0]) == 4'h0);
  assert_pci_assert_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_legacy && msg_assert && msg_dev == '0 && msg_pin == 2'd0
     && !cfg_we) |=> pirq[route[0][2:0]]);
endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0, msg_legacy = 1'b0, msg_assert = 1'b0;
  logic [5:0] msg_dev = '0;
  logic [1:0] msg_pin = '0;
  logic [3:0] msg_irq = '0;
  logic [3:0] serirq_int = '0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [7:0] pirq, apic_irq;
  logic [15:0] pic_irq;
  logic msg_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pirq_router i_pirq_router (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_legacy(msg_legacy),
    .msg_assert(msg_assert), .msg_dev(msg_dev), .msg_pin(msg_pin), .msg_irq(msg_irq),
    .serirq_int(serirq_int), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pirq(pirq), .pic_irq(pic_irq), .apic_irq(apic_irq), .msg_err(msg_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic lg, logic as, logic [5:0] dv, logic [1:0] pn, logic [3:0] iq);
    @(negedge clk);
    msg_valid = 1'b1; msg_legacy = lg; msg_assert = as;
    msg_dev = dv; msg_pin = pn; msg_irq = iq;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // {legacy, assert, dev, pin, irq, exp_pirq, exp_pic, exp_err}
  localparam logic [38:0] VEC [12] = '{
    {1'b0, 1'b1, 6'd0,  2'd0, 4'd0,  8'h01, 16'h0000, 1'b0},
    {1'b0, 1'b1, 6'd5,  2'd0, 4'd0,  8'h01, 16'h0000, 1'b0},
    {1'b0, 1'b0, 6'd0,  2'd0, 4'd0,  8'h01, 16'h0000, 1'b0},
    {1'b0, 1'b0, 6'd5,  2'd0, 4'd0,  8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b1, 6'd31, 2'd3, 4'd0,  8'h08, 16'h0000, 1'b0},
    {1'b1, 1'b1, 6'd0,  2'd0, 4'd3,  8'h08, 16'h0008, 1'b0},
    {1'b1, 1'b1, 6'd0,  2'd0, 4'd15, 8'h08, 16'h8008, 1'b0},
    {1'b1, 1'b1, 6'd0,  2'd0, 4'd5,  8'h08, 16'h8008, 1'b1},
    {1'b0, 1'b1, 6'd32, 2'd1, 4'd0,  8'h08, 16'h8008, 1'b1},
    {1'b1, 1'b0, 6'd0,  2'd0, 4'd3,  8'h08, 16'h8000, 1'b0},
    {1'b0, 1'b0, 6'd31, 2'd3, 4'd0,  8'h00, 16'h8000, 1'b0},
    {1'b1, 1'b0, 6'd0,  2'd0, 4'd15, 8'h00, 16'h0000, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 pirq", pirq, 0);
    check("R8 pic", pic_irq, 0);
    check("R8 apic", apic_irq, 0);
    check("R8 err", msg_err, 0);

    // R1 wired-OR and single-bit clear, R4 legacy levels, R6 rejects
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][38], VEC[i][37], VEC[i][36:31], VEC[i][30:29], VEC[i][28:25]);
      check($sformatf("R1 pirq vec%0d", i), pirq, VEC[i][24:17]);
      check($sformatf("R4 pic vec%0d", i), pic_irq, VEC[i][16:1]);
      check($sformatf("R6 err vec%0d", i), msg_err, VEC[i][0]);
    end

    // R6: pulse lasts one cycle
    send(1'b1, 1'b1, 6'd0, 2'd0, 4'd9);
    check("R6 err set", msg_err, 1);
    @(negedge clk);
    check("R6 err gone", msg_err, 0);
    check("R6 no state", pic_irq, 0);

    // R3 serial lines, R5 default steering to IO-APIC
    serirq_int = 4'b0101;
    #1 check("R3 serial", pirq, 8'h05);
    check("R5 apic default", apic_irq, 8'h05);
    serirq_int = 4'b0000;

    // R2/R7: remap dev2 INTB to PIRQH
    wr(6'd2, 12'h6B8);
    send(1'b0, 1'b1, 6'd2, 2'd1, 4'd0);
    check("R2 remap", pirq, 8'h80);
    check("R5 apic h", apic_irq, 8'h80);

    // R5/R7: steer PIRQH to PIC IRQ 11
    wr(6'd39, 12'h00B);
    check("R5 pic steer", pic_irq, 16'h0800);
    check("R5 apic off", apic_irq, 8'h00);

    // R7: unused address ignored
    wr(6'd40, 12'h000);
    check("R7 ignore", pic_irq, 16'h0800);
    wr(6'd63, 12'h080);
    check("R7 ignore2", pic_irq, 16'h0800);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule